// File: doc/BRIEF.md
# UART Start-Bit Baud Rate Detector

This block works out the bit rate of an incoming serial stream by timing the low period of the first start bit it sees. Software arms it with a control bit. Once armed, the block waits until the receive line has been high. It then times the next low period against a fixed oversampling reference clock. When the line goes high again, it loads a divisor into the baud rate generator so that the generator runs at sixteen times the measured bit rate.

The control bit clears itself when the measurement ends, whether the measurement succeeds or fails. The control bit is also tied to the UART enable and the receiver-idle indication. A start request takes effect only while the UART is enabled and the receiver is idle. A cancel request takes effect only while the receiver is idle. Switching the UART off drops the control bit at once.

A measurement fails in two cases: the counter runs out before the line rises, or the measured width is too short to give a usable divisor. In either case a sticky error flag is raised, and it stays set until software clears it. The baud rate generator, the receive shifter and the register interface are outside the block and appear only as ports.

Top module: `autobaud_detect`

## Requirements
- R1: After reset, `ab_active`, `ab_err`, `div_load` and `div_val` are all 0.
- R2: A write with `ctl_wr`=1 and `ctl_wdata`=1 sets `ab_active` on the next clock only when `uart_en`=1 and `rx_idle`=1. In any other case the write leaves `ab_active` at 0.
- R3: While armed, once the line has been sampled high, a low period that is sampled low on N consecutive clocks is measured as N. On the clock after the line is first sampled high again, `div_load` is 1 and `div_val` equals floor(N/16)-1 (default rounding).
- R4: `div_load` stays high for exactly one clock. In that same clock `ab_active` reads 0, while it read 1 in the clock before.
- R5: If the line is already low when the block is armed, that first low period is not measured. Timing starts only at the first falling edge that follows a high sample.
- R6: If floor(N/16) is 0 or 1, the block gives no load. Instead it sets `ab_err` and clears `ab_active` in the clock after the rising edge, and `div_val` keeps its previous value.
- R7: If the line stays low for more than 2^CNT_W-1 samples, the sample after the count saturates sets `ab_err` and clears `ab_active`. No load follows when the line later rises.
- R8: Once set, `ab_err` stays 1 until a clock on which `err_clr`=1. It reads 0 from the following clock on.
- R9: A write with `ctl_wr`=1 and `ctl_wdata`=0 clears a set `ab_active` only when `rx_idle`=1. With `rx_idle`=0 the write is ignored.
- R10: `uart_en`=0 forces `ab_active` to 0 on the next clock. An interrupted measurement never produces a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd_sync | input | 1 | Receive line, already synchronized, idle high |
| uart_en | input | 1 | UART enable |
| rx_idle | input | 1 | Receiver idle indication |
| ctl_wr | input | 1 | Software write strobe for the control bit |
| ctl_wdata | input | 1 | Value written to the control bit |
| err_clr | input | 1 | Write-one-to-clear strobe for the error flag |
| div_load | output | 1 | One-clock strobe that loads the divisor |
| div_val | output | CNT_W-OSR_LOG2 | Divisor value, held between loads |
| ab_active | output | 1 | Control bit: measurement armed or running |
| ab_err | output | 1 | Sticky measurement error flag |

## Verification
Control writes and `uart_en` changes show up on `ab_active` one clock after the edge that samples them. The bench checks that at the next falling clock edge. The measurement result, whether a load or an error, appears one clock after the edge that first samples the line high again. The bench drives the line at falling edges, counts exactly N sampling edges of low, and then checks `div_load`, `div_val` and `ab_active` half a clock after the release edge. It checks again one clock later to confirm that the strobe has dropped. For overflow, the error is due one clock after the edge that takes the 2^CNT_W-th low sample, and the bench samples at that point before it releases the line.

// File: rtl/autobaud_pkg.sv
package autobaud_pkg;

   // Timer phases for the start-bit measurement
   typedef enum logic [1:0] {
      TS_OFF       = 2'd0,
      TS_WAIT_HIGH = 2'd1,
      TS_WAIT_FALL = 2'd2,
      TS_COUNT     = 2'd3
   } abd_tstate_e;

   // Divisor rounding variants
   localparam int unsigned RND_TRUNC = 0;
   localparam int unsigned RND_HALF  = 1;

endpackage

// File: rtl/autobaud_ctl.sv
module autobaud_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic uart_en,
   input  logic rx_idle,
   input  logic ctl_wr,
   input  logic ctl_wdata,
   input  logic err_clr,
   input  logic done_ok,
   input  logic err_evt,
   output logic en,
   output logic err_flag
);

   logic en_d;
   logic err_d;
   logic set_req;
   logic clr_req;

   assign set_req = ctl_wr &  ctl_wdata & rx_idle & ~en;
   assign clr_req = ctl_wr & ~ctl_wdata & rx_idle &  en;

   always_comb begin
      if (!uart_en)
         en_d = 1'b0;
      else if (done_ok || err_evt)
         en_d = 1'b0;
      else if (set_req)
         en_d = 1'b1;
      else if (clr_req)
         en_d = 1'b0;
      else
         en_d = en;
   end

   always_comb begin
      if (err_evt)
         err_d = 1'b1;
      else if (err_clr)
         err_d = 1'b0;
      else
         err_d = err_flag;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en       <= 1'b0;
         err_flag <= 1'b0;
      end else begin
         en       <= en_d;
         err_flag <= err_d;
      end
   end

endmodule

// File: rtl/autobaud_timer.sv
module autobaud_timer
   import autobaud_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             rxd,
   output logic [CNT_W-1:0] cnt,
   output logic             fin,
   output logic             ovf
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   abd_tstate_e st_q, st_d;
   logic        in_count;
   logic        at_max;

   assign in_count = run && (st_q == TS_COUNT);
   assign at_max   = (cnt == CNT_MAX);
   assign fin      = in_count &  rxd;
   assign ovf      = in_count & ~rxd & at_max;

   always_comb begin
      st_d = st_q;
      if (!run) begin
         st_d = TS_OFF;
      end else begin
         unique case (st_q)
            TS_OFF:       st_d = rxd ? TS_WAIT_FALL : TS_WAIT_HIGH;
            TS_WAIT_HIGH: if (rxd)  st_d = TS_WAIT_FALL;
            TS_WAIT_FALL: if (!rxd) st_d = TS_COUNT;
            TS_COUNT:     if (fin || ovf) st_d = TS_OFF;
            default:      st_d = TS_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= TS_OFF;
         cnt  <= '0;
      end else begin
         st_q <= st_d;
         if (run && st_q == TS_WAIT_FALL && !rxd)
            cnt <= CNT_ONE;
         else if (in_count && !rxd && !at_max)
            cnt <= cnt + CNT_ONE;
      end
   end

endmodule

// File: rtl/autobaud_divcalc.sv
module autobaud_divcalc
   import autobaud_pkg::*;
#(
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned OSR_LOG2 = 4,
   parameter int unsigned ROUNDING = RND_TRUNC
) (
   input  logic [CNT_W-1:0]          cnt,
   output logic [CNT_W-OSR_LOG2-1:0] div,
   output logic                      div_bad
);

   localparam int unsigned Q_W = CNT_W - OSR_LOG2;

   logic [CNT_W:0] sum;
   logic [Q_W:0]   quot;
   logic [Q_W:0]   quot_m1;

   generate
      if (ROUNDING == RND_HALF) begin : g_half
         localparam logic [CNT_W:0] HALF = (CNT_W+1)'(1) << (OSR_LOG2 - 1);
         assign sum = {1'b0, cnt} + HALF;
      end else begin : g_trunc
         assign sum = {1'b0, cnt};
      end
   endgenerate

   assign quot    = sum[CNT_W:OSR_LOG2];
   assign quot_m1 = quot - (Q_W+1)'(1);
   assign div     = quot_m1[Q_W-1:0];
   assign div_bad = (quot <= (Q_W+1)'(1));

endmodule

// File: rtl/autobaud_detect.sv
module autobaud_detect
   import autobaud_pkg::*;
#(
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned OSR_LOG2 = 4,
   parameter int unsigned ROUNDING = RND_TRUNC
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      rxd_sync,
   input  logic                      uart_en,
   input  logic                      rx_idle,
   input  logic                      ctl_wr,
   input  logic                      ctl_wdata,
   input  logic                      err_clr,
   output logic                      div_load,
   output logic [CNT_W-OSR_LOG2-1:0] div_val,
   output logic                      ab_active,
   output logic                      ab_err
);

   localparam int unsigned DIV_W = CNT_W - OSR_LOG2;

   generate
      if (OSR_LOG2 < 1 || OSR_LOG2 > 8) begin : g_bad_osr
         $error("autobaud_detect: OSR_LOG2 out of range 1..8");
      end
      if (CNT_W < OSR_LOG2 + 2) begin : g_bad_cnt
         $error("autobaud_detect: CNT_W too small for OSR_LOG2");
      end
      if (ROUNDING != RND_TRUNC && ROUNDING != RND_HALF) begin : g_bad_rnd
         $error("autobaud_detect: unknown ROUNDING variant");
      end
   endgenerate

   logic             en;
   logic [CNT_W-1:0] cnt;
   logic             fin;
   logic             ovf;
   logic [DIV_W-1:0] div_calc;
   logic             div_bad;
   logic             done_ok;
   logic             err_evt;
   logic             load_q;
   logic [DIV_W-1:0] div_q;

   assign done_ok = fin & ~div_bad;
   assign err_evt = ovf | (fin & div_bad);

   autobaud_ctl u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .uart_en  (uart_en),
      .rx_idle  (rx_idle),
      .ctl_wr   (ctl_wr),
      .ctl_wdata(ctl_wdata),
      .err_clr  (err_clr),
      .done_ok  (done_ok),
      .err_evt  (err_evt),
      .en       (en),
      .err_flag (ab_err)
   );

   autobaud_timer #(.CNT_W(CNT_W)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (en),
      .rxd  (rxd_sync),
      .cnt  (cnt),
      .fin  (fin),
      .ovf  (ovf)
   );

   autobaud_divcalc #(
      .CNT_W   (CNT_W),
      .OSR_LOG2(OSR_LOG2),
      .ROUNDING(ROUNDING)
   ) u_div (
      .cnt    (cnt),
      .div    (div_calc),
      .div_bad(div_bad)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_q <= 1'b0;
         div_q  <= '0;
      end else begin
         load_q <= done_ok;
         if (done_ok)
            div_q <= div_calc;
      end
   end

   assign div_load  = load_q;
   assign div_val   = div_q;
   assign ab_active = en;

endmodule

// File: rtl/autobaud_detect_chk.sv
module autobaud_detect_chk #(
   parameter int unsigned DIV_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             uart_en,
   input logic             rx_idle,
   input logic             ctl_wr,
   input logic             ctl_wdata,
   input logic             err_clr,
   input logic             div_load,
   input logic [DIV_W-1:0] div_val,
   input logic             ab_active,
   input logic             ab_err
);

   AST_ARM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ab_active) |-> $past(uart_en && rx_idle && ctl_wr && ctl_wdata)); // R2

   AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      div_load |-> (div_val != '0)); // R3

   AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      div_load |=> !div_load); // R4

   AST_LOAD_DROPS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      div_load |-> (!ab_active && $past(ab_active))); // R4

   AST_ERR_DROPS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ab_err) |-> ($fell(ab_active) && !div_load)); // R6

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ab_err && !err_clr) |=> ab_err); // R8

   AST_SW_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (ab_active && uart_en && !rx_idle && ctl_wr && !ctl_wdata) |=> (ab_active || div_load || ab_err)); // R9

   AST_DISABLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      !uart_en |=> !ab_active); // R10

endmodule

bind autobaud_detect autobaud_detect_chk #(.DIV_W(CNT_W - OSR_LOG2)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .uart_en  (uart_en),
   .rx_idle  (rx_idle),
   .ctl_wr   (ctl_wr),
   .ctl_wdata(ctl_wdata),
   .err_clr  (err_clr),
   .div_load (div_load),
   .div_val  (div_val),
   .ab_active(ab_active),
   .ab_err   (ab_err)
);

// File: tb/autobaud_detect_test.sv
module autobaud_detect_test;

   localparam int unsigned CNT_W    = 10;
   localparam int unsigned OSR_LOG2 = 4;
   localparam int unsigned DIV_W    = CNT_W - OSR_LOG2;
   localparam int unsigned NVEC     = 10;

   // low width, expected divisor, expected error
   localparam int unsigned VEC_N   [NVEC] = '{32, 47, 48, 160, 17, 255, 31, 256, 1000, 1023};
   localparam int unsigned VEC_DIV [NVEC] = '{ 1,  1,  2,   9,  0,  14,  0,  15,   61,   62};
   localparam bit          VEC_ERR [NVEC] = '{ 0,  0,  0,   0,  1,   0,  1,   0,    0,    0};

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             rxd_sync = 1'b1;
   logic             uart_en = 1'b0;
   logic             rx_idle = 1'b1;
   logic             ctl_wr = 1'b0;
   logic             ctl_wdata = 1'b0;
   logic             err_clr = 1'b0;
   logic             div_load;
   logic [DIV_W-1:0] div_val;
   logic             ab_active;
   logic             ab_err;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;
   int unsigned last_div = 0;

   always #2 clk = ~clk;

   autobaud_detect #(.CNT_W(CNT_W), .OSR_LOG2(OSR_LOG2)) uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .rxd_sync (rxd_sync),
      .uart_en  (uart_en),
      .rx_idle  (rx_idle),
      .ctl_wr   (ctl_wr),
      .ctl_wdata(ctl_wdata),
      .err_clr  (err_clr),
      .div_load (div_load),
      .div_val  (div_val),
      .ab_active(ab_active),
      .ab_err   (ab_err)
   );

   task automatic chk(input string req, input int unsigned act, input int unsigned exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic ctl_write(input logic val);
      ctl_wr = 1'b1;
      ctl_wdata = val;
      @(negedge clk);
      ctl_wr = 1'b0;
      ctl_wdata = 1'b0;
   endtask

   task automatic clear_err();
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 active", ab_active, 0);
      chk("R1 err", ab_err, 0);
      chk("R1 load", div_load, 0);
      chk("R1 div", div_val, 0);
      rst_n = 1'b1;
      uart_en = 1'b1;
      @(negedge clk);

      // R3/R4/R6 table walk
      for (int i = 0; i < NVEC; i++) begin
         ctl_write(1'b1);
         chk("R2 armed", ab_active, 1);
         repeat (2) @(negedge clk);
         rxd_sync = 1'b0;
         repeat (VEC_N[i]) @(negedge clk);
         chk("R3 active while low", ab_active, 1);
         rxd_sync = 1'b1;
         @(negedge clk);
         if (VEC_ERR[i]) begin
            chk("R6 no load", div_load, 0);
            chk("R6 err set", ab_err, 1);
            chk("R6 active cleared", ab_active, 0);
            chk("R6 div kept", div_val, last_div);
            @(negedge clk);
            chk("R8 err sticky", ab_err, 1);
            clear_err();
            chk("R8 err cleared", ab_err, 0);
         end else begin
            chk("R3 load", div_load, 1);
            chk("R3 div", div_val, VEC_DIV[i]);
            chk("R4 active cleared with load", ab_active, 0);
            chk("R3 no err", ab_err, 0);
            last_div = VEC_DIV[i];
            @(negedge clk);
            chk("R4 load one cycle", div_load, 0);
            chk("R3 div held", div_val, last_div);
         end
         repeat (2) @(negedge clk);
      end

      // R2 gating of the arm write
      uart_en = 1'b0;
      @(negedge clk);
      ctl_write(1'b1);
      chk("R2 ignored with uart off", ab_active, 0);
      uart_en = 1'b1;
      rx_idle = 1'b0;
      @(negedge clk);
      ctl_write(1'b1);
      chk("R2 ignored when rx busy", ab_active, 0);
      rx_idle = 1'b1;
      ctl_write(1'b0);
      chk("R2 write of zero does not arm", ab_active, 0);

      // R9 software cancel needs receiver idle
      ctl_write(1'b1);
      chk("R9 armed", ab_active, 1);
      rx_idle = 1'b0;
      ctl_write(1'b0);
      chk("R9 cancel ignored while busy", ab_active, 1);
      rx_idle = 1'b1;
      ctl_write(1'b0);
      chk("R9 cancel accepted when idle", ab_active, 0);

      // R5 line already low at arm time
      rxd_sync = 1'b0;
      @(negedge clk);
      ctl_write(1'b1);
      repeat (40) @(negedge clk);
      chk("R5 still armed", ab_active, 1);
      rxd_sync = 1'b1;
      @(negedge clk);
      chk("R5 first rise gives no load", div_load, 0);
      chk("R5 first rise gives no err", ab_err, 0);
      repeat (2) @(negedge clk);
      rxd_sync = 1'b0;
      repeat (48) @(negedge clk);
      rxd_sync = 1'b1;
      @(negedge clk);
      chk("R5 load", div_load, 1);
      chk("R5 div", div_val, 2);
      last_div = 2;
      repeat (2) @(negedge clk);

      // R10 disabling the UART mid-measurement
      ctl_write(1'b1);
      repeat (2) @(negedge clk);
      rxd_sync = 1'b0;
      repeat (20) @(negedge clk);
      uart_en = 1'b0;
      @(negedge clk);
      chk("R10 active forced low", ab_active, 0);
      uart_en = 1'b1;
      repeat (20) @(negedge clk);
      rxd_sync = 1'b1;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         chk("R10 no load after abort", div_load, 0);
      end
      chk("R10 div unchanged", div_val, last_div);
      chk("R10 no err", ab_err, 0);

      // R7 counter overflow
      ctl_write(1'b1);
      repeat (2) @(negedge clk);
      rxd_sync = 1'b0;
      repeat (1 << CNT_W) @(negedge clk);
      chk("R7 err set", ab_err, 1);
      chk("R7 active cleared", ab_active, 0);
      rxd_sync = 1'b1;
      @(negedge clk);
      chk("R7 no load", div_load, 0);
      chk("R7 div unchanged", div_val, last_div);
      clear_err();
      chk("R8 err cleared after overflow", ab_err, 0);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule